// File: doc/BRIEF.md
# RC-Oscillator Conversion Timer

This block measures an unknown resistance or capacitance by racing two 16-bit up-counters. The reference counter (A) advances on a selectable internal tick: the system clock, the instruction clock or a prescaled real-time clock. The measurement counter (B) advances on one of several oscillator or external-input ticks. Software loads both counters, picks the sources, then sets the run bit. Both counters start in the same cycle. When the selected counter wraps, both freeze, the run bit drops and a sticky interrupt flag rises. The ratio of the two counts gives the measured value.

All tick sources arrive as single-cycle enable pulses that are already synchronous to `clk`. Software reaches the block through an 8-bit register port. Each counter has a high-byte and a low-byte register, and one low-byte buffer is shared by both counters, so 16-bit loads and reads are atomic. Control is a two-state machine. `ST_IDLE` goes to `ST_RUN` on the transition *start*, which is a write of 1 to the run bit. `ST_RUN` goes back to `ST_IDLE` on the transition *end*, which is the selected overflow and also sets the flag. `ST_RUN` also goes back to `ST_IDLE` on the transition *abort*, which is a write of 0 to the run bit and leaves the flag alone.

Top module: `rcadc_timer`

## Requirements
- R1: After reset both counters, the buffer, both control registers and the flag are 0, and every register reads 0x00.
- R2: Address 0 (A low) and address 2 (B low) write only the shared buffer and leave both counters unchanged. Address 1 (A high) and address 3 (B high) load that counter with {wdata, buffer} in one cycle.
- R3: A read of address 1 or 3 returns the counter's live high byte and, in the same access, copies that counter's low byte into the shared buffer. A read of address 0 or 2 returns the buffer.
- R4: Writing timer-control register (address 4) with bit 4 = 1 starts both counters in the same cycle. Bit 4 reads back 1 while running.
- R5: Timer-control bits 2:0 select counter A's tick: 000 selects the system tick, 001 the instruction tick, 010 the real-time tick, and any other value selects no tick.
- R6: Converter-control (address 5) bits 7:4 select counter B's tick. 0000 selects ext0. 0001 to 0100 select osc_ch0[0..3]. 0101 and 0110 select osc_ch1[0..1]. 0111 selects ext1. Any value 1xxx selects no tick.
- R7: In converter mode (address 5 bit 1 = 1), bit 0 selects the overflow that ends the run: 0 selects A and 1 selects B. On the 0xFFFF to 0x0000 wrap, the flag sets, the run bit clears and both counters freeze, with the wrapped counter holding 0x0000. Bits 3:2 read as 0.
- R8: In timer mode (bit 1 = 0), bit 0 has no effect, counter B holds its value, and counter A's overflow ends the run.
- R9: While running, writes to addresses 0 to 3 are ignored, reads of them return 0x00, and the buffer is unchanged.
- R10: The flag (address 6 bit 0, also output `irq`) stays set until a write to address 6 with bit 0 = 0. Writing 1 has no effect.
- R11: A run-bit write of 1 in the cycle of an ending overflow still stops the run. A run-bit write of 0 while running aborts the run without setting the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers buffer latch on high-byte reads) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tick_sys | input | 1 | System-clock tick for counter A |
| tick_instr | input | 1 | Instruction-clock tick for counter A |
| tick_rtc | input | 1 | Prescaled real-time tick for counter A |
| tick_ext0 | input | 1 | External input 0 tick for counter B |
| tick_ext1 | input | 1 | External input 1 tick for counter B |
| osc_ch0 | input | 4 | Channel 0 oscillator pairing ticks |
| osc_ch1 | input | 2 | Channel 1 oscillator pairing ticks |
| irq | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that every tick input is a clean, synchronous pulse lasting one cycle. They also assume that `wr_en` and `rd_en` are never asserted together at the same address, since the buffer checks treat a read and a write as separate accesses. The bench drives every tick and strobe at the falling edge for exactly one cycle and performs one register access at a time. It raises a tick together with a write only in the single scenario that exercises the overflow-versus-start priority.

// File: rtl/rcadc_pkg.sv
package rcadc_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int NCNT   = 2;

    localparam logic [ADDR_W-1:0] AD_A_LO = 3'd0;
    localparam logic [ADDR_W-1:0] AD_A_HI = 3'd1;
    localparam logic [ADDR_W-1:0] AD_B_LO = 3'd2;
    localparam logic [ADDR_W-1:0] AD_B_HI = 3'd3;
    localparam logic [ADDR_W-1:0] AD_TCTL = 3'd4;
    localparam logic [ADDR_W-1:0] AD_CCTL = 3'd5;
    localparam logic [ADDR_W-1:0] AD_STAT = 3'd6;

    localparam int RUN_BIT = 4;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/rcadc_tick_mux.sv
module rcadc_tick_mux #(
    parameter int N_CH0 = 4,
    parameter int N_CH1 = 2,
    parameter int ASEL_W = 3,
    parameter int BSEL_W = 4
) (
    input  logic [ASEL_W-1:0] a_sel,
    input  logic [BSEL_W-1:0] b_sel,
    input  logic              tick_sys,
    input  logic              tick_instr,
    input  logic              tick_rtc,
    input  logic              tick_ext0,
    input  logic              tick_ext1,
    input  logic [N_CH0-1:0]  osc_ch0,
    input  logic [N_CH1-1:0]  osc_ch1,
    output logic              a_tick,
    output logic              b_tick
);
    localparam int CH1_BASE = N_CH0 + 1;
    localparam int EXT1_CODE = N_CH0 + N_CH1 + 1;

    always_comb begin
        unique case (a_sel)
            ASEL_W'(0): a_tick = tick_sys;
            ASEL_W'(1): a_tick = tick_instr;
            ASEL_W'(2): a_tick = tick_rtc;
            default:    a_tick = 1'b0;
        endcase
    end

    always_comb begin
        b_tick = 1'b0;
        if (int'(b_sel) == 0)
            b_tick = tick_ext0;
        for (int i = 0; i < N_CH0; i++)
            if (int'(b_sel) == i + 1) b_tick = osc_ch0[i];
        for (int j = 0; j < N_CH1; j++)
            if (int'(b_sel) == CH1_BASE + j) b_tick = osc_ch1[j];
        if (int'(b_sel) == EXT1_CODE)
            b_tick = tick_ext1;
    end
endmodule

// File: rtl/rcadc_counter.sv
module rcadc_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] cnt,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] MAXV = '1;

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (en && tick)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
    assign ovf = en && tick && (cnt_q == MAXV);

    // R2: a high-byte write commits the full 16-bit value
    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    // R7: a stopped counter stays frozen
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt_q));
    // R7: the wrap lands on zero
    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !load) |=> cnt_q == '0);
endmodule

// File: rtl/rcadc_ctrl.sv
module rcadc_ctrl
    import rcadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    input  logic end_ovf,
    output logic running,
    output logic flag_set
);
    run_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start_req) st_d = ST_RUN;
            ST_RUN: begin
                if (end_ovf)       st_d = ST_IDLE;
                else if (stop_req) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running  = (st_q == ST_RUN);
        flag_set = (st_q == ST_RUN) && end_ovf;
    end

    // R7: the selected overflow ends the run
    p_stop_on_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && end_ovf) |=> !running);
    // R11: a concurrent start does not override the stop
    p_overflow_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (running && end_ovf && start_req) |=> (st_q == ST_IDLE));
    // R4: start moves the machine to the run state
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start_req) |=> running);
endmodule

// File: rtl/rcadc_timer.sv
module rcadc_timer
    import rcadc_pkg::*;
#(
    parameter int N_CH0 = 4,
    parameter int N_CH1 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_sys,
    input  logic              tick_instr,
    input  logic              tick_rtc,
    input  logic              tick_ext0,
    input  logic              tick_ext1,
    input  logic [N_CH0-1:0]  osc_ch0,
    input  logic [N_CH1-1:0]  osc_ch1,
    output logic              irq
);
    localparam int ASEL_W = 3;
    localparam int BSEL_W = 4;

    logic [ASEL_W-1:0] a_sel_q;
    logic [BSEL_W-1:0] b_sel_q;
    logic              conv_mode_q;
    logic              ovf_sel_q;
    logic [DATA_W-1:0] lobuf_q;
    logic              flag_q;

    logic              busy;
    logic              flag_set;
    logic              end_ovf;
    logic              start_req, stop_req;
    logic              a_tick, b_tick;
    logic [CNT_W-1:0]  cnt_val  [NCNT];
    logic              cnt_ovf  [NCNT];
    logic              cnt_tick [NCNT];
    logic              cnt_en   [NCNT];
    logic              cnt_load [NCNT];

    logic wr_tctl, wr_cctl, wr_stat, wr_lo, flag_clr;

    assign wr_tctl  = wr_en && (addr == AD_TCTL);
    assign wr_cctl  = wr_en && (addr == AD_CCTL);
    assign wr_stat  = wr_en && (addr == AD_STAT);
    assign wr_lo    = wr_en && !busy && ((addr == AD_A_LO) || (addr == AD_B_LO));
    assign flag_clr = wr_stat && !wdata[0];

    assign start_req = wr_tctl && wdata[RUN_BIT];
    assign stop_req  = wr_tctl && !wdata[RUN_BIT];

    rcadc_tick_mux #(
        .N_CH0(N_CH0), .N_CH1(N_CH1), .ASEL_W(ASEL_W), .BSEL_W(BSEL_W)
    ) u_mux (
        .a_sel(a_sel_q), .b_sel(b_sel_q),
        .tick_sys(tick_sys), .tick_instr(tick_instr), .tick_rtc(tick_rtc),
        .tick_ext0(tick_ext0), .tick_ext1(tick_ext1),
        .osc_ch0(osc_ch0), .osc_ch1(osc_ch1),
        .a_tick(a_tick), .b_tick(b_tick)
    );

    assign cnt_tick[0] = a_tick;
    assign cnt_tick[1] = b_tick;
    assign cnt_en[0]   = busy;
    assign cnt_en[1]   = busy && conv_mode_q;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 * g + 1);
        assign cnt_load[g] = wr_en && !busy && (addr == HI_ADDR);
        rcadc_counter #(.WIDTH(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .en(cnt_en[g]), .tick(cnt_tick[g]),
            .load(cnt_load[g]), .load_val({wdata, lobuf_q}),
            .cnt(cnt_val[g]), .ovf(cnt_ovf[g])
        );
    end

    assign end_ovf = (conv_mode_q && ovf_sel_q) ? cnt_ovf[1] : cnt_ovf[0];

    rcadc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .stop_req(stop_req), .end_ovf(end_ovf),
        .running(busy), .flag_set(flag_set)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sel_q     <= '0;
            b_sel_q     <= '0;
            conv_mode_q <= 1'b0;
            ovf_sel_q   <= 1'b0;
        end else begin
            if (wr_tctl) a_sel_q <= wdata[ASEL_W-1:0];
            if (wr_cctl) begin
                b_sel_q     <= wdata[7:4];
                conv_mode_q <= wdata[1];
                ovf_sel_q   <= wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lobuf_q <= '0;
        else if (wr_lo)
            lobuf_q <= wdata;
        else if (rd_en && !busy && addr == AD_A_HI)
            lobuf_q <= cnt_val[0][DATA_W-1:0];
        else if (rd_en && !busy && addr == AD_B_HI)
            lobuf_q <= cnt_val[1][DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (flag_set) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign irq = flag_q;

    always_comb begin
        rdata = '0;
        unique case (addr)
            AD_A_LO, AD_B_LO: rdata = busy ? '0 : lobuf_q;
            AD_A_HI: rdata = busy ? '0 : cnt_val[0][CNT_W-1:DATA_W];
            AD_B_HI: rdata = busy ? '0 : cnt_val[1][CNT_W-1:DATA_W];
            AD_TCTL: rdata = {3'b000, busy, 1'b0, a_sel_q};
            AD_CCTL: rdata = {b_sel_q, 2'b00, conv_mode_q, ovf_sel_q};
            AD_STAT: rdata = {7'b0, flag_q};
            default: rdata = '0;
        endcase
    end

    // R9: locked byte registers leave the buffer untouched
    p_locked_buffer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_en || rd_en) && addr < AD_TCTL) |=> $stable(lobuf_q));
    // R10: flag holds until cleared
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    // R8: counter B does not move in timer mode
    p_b_hold_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_mode_q && !cnt_load[1]) |=> $stable(cnt_val[1]));
    // R7: flag rises only when the run ends
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> !busy);
endmodule

// File: tb/sim_rcadc_timer.sv
module sim_rcadc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick_sys = 0, tick_instr = 0, tick_rtc = 0, tick_ext0 = 0, tick_ext1 = 0;
    logic [3:0] osc_ch0 = '0;
    logic [1:0] osc_ch1 = '0;
    logic       irq;

    int n_chk = 0, n_fail = 0, cycles = 0;

    always #10 clk = ~clk;

    rcadc_timer u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tick_sys(tick_sys), .tick_instr(tick_instr),
        .tick_rtc(tick_rtc), .tick_ext0(tick_ext0), .tick_ext1(tick_ext1),
        .osc_ch0(osc_ch0), .osc_ch1(osc_ch1), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] hi, output logic [15:0] v);
        logic [7:0] h, l;
        rd(hi, h);
        rd(hi - 3'd1, l);
        v = {h, l};
    endtask

    task automatic ld16(input logic [2:0] hi, input logic [15:0] v);
        wr(hi - 3'd1, v[7:0]);
        wr(hi, v[15:8]);
    endtask

    // pulse: bit0 sys, 1 instr, 2 rtc, 3 ext0, 4 ext1, 8:5 ch0, 10:9 ch1
    task automatic pulse(input logic [10:0] p);
        @(negedge clk);
        {osc_ch1, osc_ch0, tick_ext1, tick_ext0, tick_rtc, tick_instr, tick_sys} = p;
        @(negedge clk);
        {osc_ch1, osc_ch0, tick_ext1, tick_ext0, tick_rtc, tick_instr, tick_sys} = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset read", {8'h0, d}, 16'h0);
        end
        chk("R1 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_bytes;
        logic [15:0] v;
        logic [7:0] d;
        ld16(3'd1, 16'h1234);
        ld16(3'd3, 16'h5678);
        rd16(3'd1, v); chk("R2/R3 A load", v, 16'h1234);
        wr(3'd0, 8'h99);
        rd(3'd1, d); chk("R2 low write no effect", {8'h0, d}, 16'h0012);
        rd(3'd0, d); chk("R3 latch on high read", {8'h0, d}, 16'h0034);
        rd16(3'd3, v); chk("R2/R3 B load", v, 16'h5678);
        rd(3'd0, d); chk("R3 shared buffer", {8'h0, d}, 16'h0078);
    endtask

    task automatic t_asel;
        logic [15:0] v;
        logic [7:0] d;
        ld16(3'd1, 16'h0100);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h11);               // instr tick
        rd(3'd4, d); chk("R4 run readback", {8'h0, d}, 16'h0011);
        pulse(11'h002); pulse(11'h001); pulse(11'h002); pulse(11'h004);
        wr(3'd4, 8'h00);
        rd16(3'd1, v); chk("R5 instr select", v, 16'h0102);
        wr(3'd4, 8'h13);               // no-tick select
        pulse(11'h007);
        wr(3'd4, 8'h00);
        rd16(3'd1, v); chk("R5 select 011 none", v, 16'h0102);
        chk("R11 abort no flag", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_bsel;
        logic [15:0] v;
        ld16(3'd3, 16'h0000);
        wr(3'd5, 8'h32);               // ch0[2], converter mode
        wr(3'd4, 8'h10);
        pulse(11'h080); pulse(11'h020); pulse(11'h080); pulse(11'h010);
        wr(3'd4, 8'h00);
        rd16(3'd3, v); chk("R6 code 0011 -> ch0[2]", v, 16'h0002);
        ld16(3'd3, 16'h0005);
        wr(3'd5, 8'h83);               // 1xxx
        wr(3'd4, 8'h10);
        pulse(11'h7F8);
        wr(3'd4, 8'h00);
        rd16(3'd3, v); chk("R6 1xxx no tick", v, 16'h0005);
    endtask

    task automatic t_end_a;
        logic [15:0] v;
        logic [7:0] d;
        ld16(3'd1, 16'hFFFE);
        ld16(3'd3, 16'h0010);
        wr(3'd5, 8'h52);               // ch1[0], converter, end on A
        wr(3'd4, 8'h10);
        pulse(11'h201); pulse(11'h201);
        chk("R7 flag on A ovf", {15'h0, irq}, 16'h1);
        pulse(11'h201);
        rd(3'd4, d); chk("R7 run cleared", {8'h0, d}, 16'h0000);
        rd16(3'd1, v); chk("R7 A frozen at 0", v, 16'h0000);
        rd16(3'd3, v); chk("R7 B frozen", v, 16'h0012);
        rd(3'd5, d); chk("R7 cctl bits 3:2 zero", {8'h0, d}, 16'h0052);
        wr(3'd6, 8'h01);
        chk("R10 write 1 keeps flag", {15'h0, irq}, 16'h1);
        wr(3'd6, 8'h00);
        chk("R10 clear", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_end_b;
        logic [15:0] v;
        logic [7:0] d;
        ld16(3'd1, 16'h0000);
        ld16(3'd3, 16'hFFFF);
        wr(3'd5, 8'h73);               // ext1, converter, end on B
        wr(3'd4, 8'h11);
        pulse(11'h002); pulse(11'h00A); pulse(11'h002);
        wr(3'd1, 8'h55);
        rd(3'd1, d); chk("R9 locked read", {8'h0, d}, 16'h0000);
        pulse(11'h010);
        chk("R7 flag on B ovf", {15'h0, irq}, 16'h1);
        rd16(3'd1, v); chk("R9 write ignored / A count", v, 16'h0003);
        rd16(3'd3, v); chk("R7 B wrapped", v, 16'h0000);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_timer_mode;
        logic [15:0] v;
        logic [7:0] d;
        ld16(3'd1, 16'hFFFF);
        ld16(3'd3, 16'hFFFF);
        wr(3'd5, 8'h01);               // timer mode, select bit set
        wr(3'd4, 8'h10);
        pulse(11'h008);
        rd(3'd4, d); chk("R8 still running", {8'h0, d}, 16'h0010);
        pulse(11'h001);
        chk("R8 A ends run", {15'h0, irq}, 16'h1);
        rd16(3'd3, v); chk("R8 B held", v, 16'hFFFF);
        rd16(3'd1, v); chk("R8 A wrapped", v, 16'h0000);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_priority;
        logic [7:0] d;
        ld16(3'd1, 16'hFFFF);
        wr(3'd5, 8'h02);
        wr(3'd4, 8'h10);
        @(negedge clk);
        addr = 3'd4; wdata = 8'h10; wr_en = 1'b1; tick_sys = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_sys = 1'b0;
        rd(3'd4, d); chk("R11 overflow beats start", {8'h0, d}, 16'h0000);
        chk("R11 flag set", {15'h0, irq}, 16'h1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bytes();
        t_asel();
        t_bsel();
        t_end_a();
        t_end_b();
        t_timer_mode();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule